// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block models how a NOR flash device reports progress while its embedded controller programs a word or erases the array. A clocked bus carries the host's accesses. In each clock cycle, a high write strobe counts as one write cycle and a high read strobe counts as one read cycle. Command sequences start a program, start an erase or change the status mode. A cycle counter sets how long each operation stays busy. A small register file stands in for the cell array, and a digital supply-good input stands in for the programming-voltage check.

A one-bit status mode decides what happens after an operation. In auto-return mode (value 0), a successful operation puts the device back into array reads by itself. In hold mode (value 1), the device stays in status mode until the host writes an exit command. A failed operation always stays in status mode until the exit command. While status is shown, bit 7 carries the polling indication and bit 6 is the toggle bit. Bit 5 flags a failure and bit 3 flags a supply fault. All other status bits read 0.

The controller has three states. READ returns array words. BUSY marks a running operation. STATUS holds the device after a finish in hold mode or after a failure. The transitions are:
- READ→BUSY: a program or erase is launched with the supply good.
- READ→STATUS: a launch is refused because the supply is low.
- BUSY→READ: the timer expires in auto-return mode.
- BUSY→STATUS: the timer expires in hold mode, or the supply drops.
- STATUS→READ: the exit command is written.

Top module: `nor_pe_status`

## Requirements
- R1: After power-up (`por_n` low) the status mode is auto-return (0). A mode write only takes effect when its data word is exactly 0x0000 or 0x0001. Any other value leaves the mode unchanged. After power-up every array word reads 0xFFFF and `rdata` is 0.
- R2: Asserting `rst_n` returns the controller to READ and clears the toggle bit to 0. It does not change the status mode.
- R3: The status mode is written by four write cycles in this order: address 0x555 data 0xAA, address 0x2AA data 0x55, address 0x555 data 0xD0, then any address with the new value.
- R4: A program is started by 0x555/0xAA, 0x2AA/0x55 and 0x555/0xA0, followed by the target address and data. An erase is started by the same two unlock cycles, then 0x555/0x80, then any address with data 0x0030, and it sets every word to 0xFFFF. Any write that does not match the expected step drops the sequence and starts nothing. The array word is chosen by the low address bits.
- R5: In auto-return mode, a successful operation moves the controller straight back to READ, and the new array contents are readable.
- R6: In hold mode, a successful operation leaves the controller in STATUS with bit 7 = 1 and bit 5 = 0. Writes other than the exit command (data 0x00F0) are ignored there. After the exit command, array reads resume.
- R7: A failed operation, in either mode, stays in STATUS until the exit command. A refused operation leaves the array unchanged.
- R8: In auto-return mode, while busy or failed, status bit 7 is the complement of bit 7 of the programmed data word. For an erase it is 0.
- R9: In hold mode, status bit 7 reads 0 while busy and 1 in STATUS.
- R10: Status bit 6 inverts on every read in BUSY and on every read in a failed STATUS. It holds its value on reads in a successful STATUS.
- R11: A launch with `supply_ok` low is refused. So is a running operation during which `supply_ok` drops. Either way the controller enters STATUS with bits 5 and 3 set, and the target word is not written.
- R12: While BUSY, every write is ignored, including the exit command and new command sequences.
- R13: A program stays busy for exactly PROG_CYC cycles and an erase for ERASE_CYC cycles, counted from the cycle after the final command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| por_n | input | 1 | Power-on reset, active low; also clears the status mode and the array |
| rst_n | input | 1 | Hardware reset, active low; leaves the status mode alone |
| addr | input | AW | Word address of the bus cycle |
| wdata | input | DW | Write data / command word |
| we | input | 1 | Write strobe: one write cycle per high clock cycle |
| oe | input | 1 | Read strobe: one read cycle per high clock cycle |
| supply_ok | input | 1 | Programming supply above threshold |
| rdata | output | DW | Registered read data: array word or status word |

## Verification
The checker watches several rules on every cycle. A low hardware reset never alters the mode. A refused launch always lands in a failed STATUS. The busy state cannot end early while the supply holds. Bit 7 has the polarity fixed by the mode in BUSY and STATUS. Bit 6 flips on back-to-back busy reads and stays put on back-to-back reads of a successful status. Only the bench scenarios can show the end-to-end behaviour: the exact busy length, the array contents after program, erase and refusal, wrong or illegal command sequences being ignored, and the mode surviving a hardware reset.

// File: rtl/nps_pkg.sv
package nps_pkg;
    typedef enum logic [1:0] {
        ST_READ   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_STATUS = 2'd2
    } pe_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef enum logic {
        MODE_AUTO = 1'b0,
        MODE_HOLD = 1'b1
    } stat_mode_e;

    localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
    localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  OPC_PROG      = 8'hA0;
    localparam logic [7:0]  OPC_ERASE     = 8'h80;
    localparam logic [7:0]  OPC_MODE      = 8'hD0;
    localparam logic [7:0]  ERASE_OK      = 8'h30;
    localparam logic [7:0]  OPC_EXIT      = 8'hF0;
endpackage

// File: rtl/nps_cmd_seq.sv
module nps_cmd_seq
    import nps_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          go_prog,
    output logic          go_erase,
    output logic          mode_wr,
    output logic          mode_val,
    output logic          exit_cmd
);
    localparam logic [AW-1:0] ADR_A = AW'(UNLOCK_ADDR_A);
    localparam logic [AW-1:0] ADR_B = AW'(UNLOCK_ADDR_B);

    typedef enum logic [2:0] {
        CS_IDLE, CS_KEY1, CS_KEY2, CS_PROG, CS_ERASE, CS_MODE
    } cs_e;

    cs_e cs_q, cs_d;

    function automatic logic is_word(input logic [DW-1:0] w, input logic [7:0] code);
        return w == DW'(code);
    endfunction

    assign exit_cmd = we && is_word(wdata, OPC_EXIT);

    always_comb begin
        cs_d     = cs_q;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        mode_wr  = 1'b0;
        mode_val = wdata[0];
        if (!en) begin
            cs_d = CS_IDLE;
        end else if (we) begin
            unique case (cs_q)
                CS_IDLE:
                    cs_d = (addr == ADR_A && is_word(wdata, KEY_FIRST)) ? CS_KEY1 : CS_IDLE;
                CS_KEY1:
                    cs_d = (addr == ADR_B && is_word(wdata, KEY_SECOND)) ? CS_KEY2 : CS_IDLE;
                CS_KEY2: begin
                    cs_d = CS_IDLE;
                    if (addr == ADR_A && is_word(wdata, OPC_PROG))  cs_d = CS_PROG;
                    if (addr == ADR_A && is_word(wdata, OPC_ERASE)) cs_d = CS_ERASE;
                    if (addr == ADR_A && is_word(wdata, OPC_MODE))  cs_d = CS_MODE;
                end
                CS_PROG: begin
                    go_prog = 1'b1;
                    cs_d    = CS_IDLE;
                end
                CS_ERASE: begin
                    go_erase = is_word(wdata, ERASE_OK);
                    cs_d     = CS_IDLE;
                end
                CS_MODE: begin
                    mode_wr = (wdata == '0) || (wdata == DW'(1));
                    cs_d    = CS_IDLE;
                end
                default: cs_d = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= CS_IDLE;
        else        cs_q <= cs_d;
    end
endmodule

// File: rtl/nps_busy_timer.sv
module nps_busy_timer
    import nps_pkg::*;
#(
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_kind_e kind,
    input  logic     run,
    output logic     done
);
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (start)               cnt_q <= (kind == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == '0);
endmodule

// File: rtl/nps_cell_array.sv
module nps_cell_array #(
    parameter int DEPTH = 16,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     clr_all,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/nor_pe_status.sv
module nor_pe_status
    import nps_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int DEPTH     = 16,
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 24
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    input  logic          oe,
    input  logic          supply_ok,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(DEPTH);

    logic       rst_all_n;
    pe_state_e  st_q, st_d;
    stat_mode_e cfg_q;
    op_kind_e   op_q;
    logic [IW-1:0] tgt_idx_q;
    logic [DW-1:0] tgt_data_q;
    logic fail_q, vlow_q, tog_q;
    logic go_prog, go_erase, mode_wr, mode_val, exit_cmd;
    logic launch, tmr_done, commit, poll_bit;
    logic [DW-1:0] arr_rd, stat_word;

    assign rst_all_n = rst_n & por_n;

    nps_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_all_n), .en(st_q == ST_READ), .we(we),
        .addr(addr), .wdata(wdata), .go_prog(go_prog), .go_erase(go_erase),
        .mode_wr(mode_wr), .mode_val(mode_val), .exit_cmd(exit_cmd)
    );

    assign launch = (st_q == ST_READ) && (go_prog || go_erase) && supply_ok;
    assign commit = (st_q == ST_BUSY) && supply_ok && tmr_done;

    nps_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_all_n), .start(launch),
        .kind(go_erase ? OP_ERASE : OP_PROG),
        .run(st_q == ST_BUSY), .done(tmr_done)
    );

    nps_cell_array #(.DEPTH(DEPTH), .DW(DW)) u_arr (
        .clk(clk), .por_n(por_n),
        .wr_en(commit && op_q == OP_PROG), .wr_idx(tgt_idx_q), .wr_data(tgt_data_q),
        .clr_all(commit && op_q == OP_ERASE),
        .rd_idx(addr[IW-1:0]), .rd_data(arr_rd)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READ:
                if (go_prog || go_erase) st_d = supply_ok ? ST_BUSY : ST_STATUS;
            ST_BUSY:
                if (!supply_ok)    st_d = ST_STATUS;
                else if (tmr_done) st_d = (cfg_q == MODE_HOLD) ? ST_STATUS : ST_READ;
            ST_STATUS:
                if (exit_cmd) st_d = ST_READ;
            default: st_d = ST_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) st_q <= ST_READ;
        else            st_q <= st_d;
    end

    // mode register: only power-on clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       cfg_q <= MODE_AUTO;
        else if (mode_wr) cfg_q <= stat_mode_e'(mode_val);
    end

    // operation context and fault flags
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            op_q       <= OP_PROG;
            tgt_idx_q  <= '0;
            tgt_data_q <= '0;
            fail_q     <= 1'b0;
            vlow_q     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_READ:
                    if (go_prog || go_erase) begin
                        op_q       <= go_erase ? OP_ERASE : OP_PROG;
                        tgt_idx_q  <= addr[IW-1:0];
                        tgt_data_q <= wdata;
                        fail_q     <= !supply_ok;
                        vlow_q     <= !supply_ok;
                    end
                ST_BUSY:
                    if (!supply_ok) begin
                        fail_q <= 1'b1;
                        vlow_q <= 1'b1;
                    end
                ST_STATUS:
                    if (exit_cmd) begin
                        fail_q <= 1'b0;
                        vlow_q <= 1'b0;
                    end
                default: ;
            endcase
        end
    end

    // status word assembly
    always_comb begin
        if (cfg_q == MODE_HOLD) poll_bit = (st_q == ST_STATUS);
        else                    poll_bit = (op_q == OP_ERASE) ? 1'b0 : ~tgt_data_q[7];
        stat_word    = '0;
        stat_word[7] = poll_bit;
        stat_word[6] = tog_q;
        stat_word[5] = fail_q;
        stat_word[3] = vlow_q;
    end

    // outputs: read data and toggle bit
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            rdata <= '0;
            tog_q <= 1'b0;
        end else if (oe) begin
            rdata <= (st_q == ST_READ) ? arr_rd : stat_word;
            if (st_q == ST_BUSY || (st_q == ST_STATUS && fail_q)) tog_q <= ~tog_q;
        end
    end
endmodule

// File: rtl/nps_chk.sv
module nps_chk
    import nps_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          por_n,
    input logic          rst_n,
    input logic          we,
    input logic          oe,
    input logic [DW-1:0] wdata,
    input logic          supply_ok,
    input logic [DW-1:0] rdata,
    input pe_state_e     st,
    input stat_mode_e    cfg,
    input logic          fail,
    input logic          go_prog,
    input logic          go_erase,
    input logic          tmr_done
);
    // R2
    cfg_keep_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (cfg == $past(cfg)));

    // R11
    refuse_fail_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (st == ST_READ && (go_prog || go_erase) && !supply_ok) |=> (st == ST_STATUS && fail));

    // R13
    busy_stay_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (st == ST_BUSY && supply_ok && !tmr_done) |=> (st == ST_BUSY));

    // R5
    status_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (st == ST_STATUS) |-> (cfg == MODE_HOLD || fail));

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (st == ST_STATUS && !(we && wdata == DW'(8'hF0))) |=> (st == ST_STATUS));

    // R9
    hold_busy_low_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (oe && st == ST_BUSY && cfg == MODE_HOLD) |=> (rdata[7] == 1'b0));

    // R9
    hold_done_high_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (oe && st == ST_STATUS && cfg == MODE_HOLD) |=> rdata[7]);

    // R10
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (oe && st == ST_BUSY && $past(oe && st == ST_BUSY)) |=> (rdata[6] != $past(rdata[6])));

    // R10
    toggle_still_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (oe && st == ST_STATUS && !fail && $past(oe && st == ST_STATUS)) |=> $stable(rdata[6]));
endmodule

bind nor_pe_status nps_chk #(.DW(DW)) u_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(we), .oe(oe), .wdata(wdata),
    .supply_ok(supply_ok), .rdata(rdata), .st(st_q), .cfg(cfg_q), .fail(fail_q),
    .go_prog(go_prog), .go_erase(go_erase), .tmr_done(tmr_done)
);

// File: tb/sim_nor_pe_status.sv
module sim_nor_pe_status;
    localparam int CLK_NS = 10;
    localparam int PROG_N = 12;
    localparam int ERASE_N = 24;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic we = 1'b0, oe = 1'b0, supply_ok = 1'b1;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit tb_tog = 1'b0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    nor_pe_status #(.AW(12), .DW(16), .DEPTH(16), .PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .we(we), .oe(oe), .supply_ok(supply_ok), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: one scoreboard entry per sampled read cycle
    initial begin
        forever begin
            @(posedge clk);
            if (oe) begin
                #2;
                if (exp_q.size() == 0) check("scoreboard", rdata, 16'hxxxx);
                else check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [15:0] sw(input bit b7, input bit b6, input bit b5, input bit b3);
        logic [15:0] w = '0;
        w[7] = b7; w[6] = b6; w[5] = b5; w[3] = b3;
        return w;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); we = 1'b1; oe = 1'b0; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] e, input string tag);
        @(negedge clk); we = 1'b0; oe = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    // read that the design answers with a toggling status word
    task automatic rd_tog(input bit b7, input bit b5, input bit b3, input string tag);
        rd(12'h0, sw(b7, tb_tog, b5, b3), tag);
        tb_tog = ~tb_tog;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); we = 1'b0; oe = 1'b0; end
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
    endtask

    task automatic cmd_prog(input logic [11:0] a, input logic [15:0] d);
        unlock(); wr(12'h555, 16'h00A0); wr(a, d);
    endtask

    task automatic cmd_erase(input logic [15:0] confirm);
        unlock(); wr(12'h555, 16'h0080); wr(12'h0, confirm);
    endtask

    task automatic cmd_mode(input logic [15:0] v);
        unlock(); wr(12'h555, 16'h00D0); wr(12'h0, v);
    endtask

    task automatic cmd_exit();
        wr(12'h0, 16'h00F0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++; checks++;
        $display("FAIL watchdog: run did not end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // power-up
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rdata", rdata, 16'h0000);
        rd(12'h003, 16'hFFFF, "R1 array after power-up");

        // auto-return program, bit7 of data = 0 -> poll 1; full busy length
        cmd_prog(12'h003, 16'h1234);
        rd_tog(1, 0, 0, "R8 poll complement");
        for (int i = 1; i < PROG_N; i++) rd_tog(1, 0, 0, "R13 R10 busy read");
        rd(12'h003, 16'h1234, "R5 auto return with data");
        idle(2);

        // data bit7 = 1 -> poll 0
        cmd_prog(12'h005, 16'h00A5);
        rd_tog(0, 0, 0, "R8 poll complement high bit");
        rd_tog(0, 0, 0, "R10 toggle");
        idle(PROG_N + 2);
        rd(12'h005, 16'h00A5, "R5 second program");

        // erase, exact busy length
        cmd_erase(16'h0030);
        rd_tog(0, 0, 0, "R8 erase poll low");
        for (int i = 1; i < ERASE_N; i++) rd_tog(0, 0, 0, "R13 erase busy");
        rd(12'h005, 16'hFFFF, "R4 R13 erased word");

        // writes ignored while busy
        cmd_prog(12'h007, 16'h0F0F);
        cmd_exit();
        cmd_prog(12'h009, 16'h0000);
        rd_tog(1, 0, 0, "R12 still busy after writes");
        idle(PROG_N + 2);
        rd(12'h007, 16'h0F0F, "R12 first program intact");
        rd(12'h009, 16'hFFFF, "R12 nested program ignored");

        // refused launch with supply low
        @(negedge clk); we = 1'b0; oe = 1'b0; supply_ok = 1'b0;
        cmd_prog(12'h007, 16'h1111);
        rd_tog(1, 1, 1, "R11 refused status");
        rd_tog(1, 1, 1, "R10 failed status toggles");
        @(negedge clk); we = 1'b0; oe = 1'b0; supply_ok = 1'b1;
        idle(PROG_N + 2);
        rd_tog(1, 1, 1, "R7 failure persists");
        cmd_exit();
        rd(12'h007, 16'h0F0F, "R7 refused left array");

        // supply drop during operation
        cmd_prog(12'h009, 16'h2222);
        rd_tog(1, 0, 0, "R11 busy before drop");
        @(negedge clk); we = 1'b0; oe = 1'b0; supply_ok = 1'b0;
        @(negedge clk); we = 1'b0; oe = 1'b0; supply_ok = 1'b1;
        rd_tog(1, 1, 1, "R11 aborted status");
        cmd_exit();
        rd(12'h009, 16'hFFFF, "R11 aborted word unwritten");

        // hold mode
        cmd_mode(16'h0001);
        cmd_prog(12'h002, 16'h8001);
        rd_tog(0, 0, 0, "R9 hold busy low");
        rd_tog(0, 0, 0, "R9 hold busy low again");
        idle(PROG_N + 2);
        rd(12'h002, sw(1, tb_tog, 0, 0), "R6 hold done status");
        rd(12'h002, sw(1, tb_tog, 0, 0), "R10 no toggle when done");
        wr(12'h002, 16'h1234);
        rd(12'h002, sw(1, tb_tog, 0, 0), "R6 non-exit write ignored");
        cmd_exit();
        rd(12'h002, 16'h8001, "R6 exit to array");

        // illegal mode value keeps hold mode
        cmd_mode(16'h0002);
        cmd_prog(12'h004, 16'h0044);
        idle(PROG_N + 2);
        rd(12'h004, sw(1, tb_tog, 0, 0), "R1 illegal mode ignored");
        cmd_exit();
        idle(1);

        // hardware reset keeps the mode
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; tb_tog = 1'b0;
        @(negedge clk);
        check("R2 reset rdata", rdata, 16'h0000);
        cmd_prog(12'h006, 16'h0066);
        idle(PROG_N + 2);
        rd(12'h006, sw(1, tb_tog, 0, 0), "R2 mode kept through reset");
        cmd_exit();
        rd(12'h006, 16'h0066, "R2 data after exit");

        // failure in hold mode
        @(negedge clk); we = 1'b0; oe = 1'b0; supply_ok = 1'b0;
        cmd_erase(16'h0030);
        rd_tog(1, 1, 1, "R7 hold mode failed erase");
        @(negedge clk); we = 1'b0; oe = 1'b0; supply_ok = 1'b1;
        cmd_exit();
        rd(12'h004, 16'h0044, "R7 erase refused array kept");

        // back to auto-return
        cmd_mode(16'h0000);
        cmd_prog(12'h008, 16'h0088);
        idle(PROG_N + 2);
        rd(12'h008, 16'h0088, "R3 auto mode restored");

        // broken sequences start nothing
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0056); wr(12'h555, 16'h00A0); wr(12'h00A, 16'h0000);
        rd(12'h00A, 16'hFFFF, "R4 wrong key ignored");
        cmd_erase(16'h0031);
        rd(12'h008, 16'h0088, "R4 wrong confirm ignored");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 scoreboard: pending=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule